// File: doc/BRIEF.md
# Bus Mastership Token-Passing Controller

This block sits in each bus administrator node of a multi-master field bus. Several such nodes form a logical ring and take turns as the single active master. The controller tracks whether its node is the active master or a standby. When a turn ends, it asks the next ring member for its device status. It offers mastership only to a member that reports itself eligible, and then retires. A standby node takes mastership when it accepts an offer, or when the bus has been silent for longer than its own time-out. A master that hears another node's master-issued frame assumes a collision and falls back to standby.

Frames reach the block as a one-cycle receive strobe carrying a 3-bit kind, a source address, a destination address and a one-bit flag. The block sends frames through a registered request of the same shape. The kind codes are: 0 = mastership offer, 1 = offer reply, 2 = status query, 3 = status reply, 4 = ordinary master frame. The flag means "eligible" in a status reply and "accept" in an offer reply. An ordinary master frame is broadcast to the all-ones address. The turn length, the reply window and the silence time-out are run-time cycle counts. The ring list is a packed vector of addresses, in which entry i sits at bits [i*AW +: AW].

Top module: `bus_token_ctrl`

## Requirements
- R1: During and right after reset, `is_master` equals `init_master`, `tx_valid` is 0 and `collision` is 0.
- R2: A master that has just started a turn stays in it for exactly `turn_len` cycles. It then sends a status query (kind 2) to the current ring entry, which is entry 0 after reset.
- R3: A status reply (kind 3) with flag 1, coming from the queried entry and addressed to this node, makes the node send a mastership offer (kind 0) to that entry in the next cycle.
- R4: A status reply with flag 0, or no status reply within `reply_len` cycles of the query, keeps the node master for one more turn. That turn starts with a master frame (kind 4), and the next query goes to the following ring entry. The index wraps from the last entry back to entry 0.
- R5: After an offer, an offer reply (kind 1) with flag 1 from the offered entry, or no reply within `reply_len` cycles, drops the node to standby.
- R6: An offer reply with flag 0 keeps the node master for one more turn. That turn starts with a master frame, and the next query goes to the following ring entry.
- R7: A standby node answers a status query addressed to it with a status reply carrying `admin_ok`, sent to the querier. It answers an offer addressed to it with an offer reply carrying `admin_ok`. It becomes master in the same cycle when `admin_ok` is 1. Each answer appears one cycle after the received frame.
- R8: A standby node becomes master, and sends a master frame, after `standby_len` consecutive cycles with no received frame. Any received frame restarts this count.
- R9: A master that receives a master frame, a status query or an offer from any source other than `my_addr` goes to standby in the next cycle and pulses `collision` for one cycle. Such frames carrying its own source address have no effect.
- R10: A standby node does not answer frames addressed to another node. A master ignores a status reply from a node it did not query.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_master | input | 1 | Role taken at reset: 1 = master |
| admin_ok | input | 1 | This node is a configured, up-to-date administrator |
| my_addr | input | AW | Own bus address |
| ring_list | input | RING*AW | Ring successor addresses, entry i at [i*AW +: AW] |
| turn_len | input | CW | Turn length in cycles |
| reply_len | input | CW | Reply window in cycles |
| standby_len | input | CW | Silence time-out in cycles |
| rx_valid | input | 1 | Received-frame strobe |
| rx_kind | input | 3 | Received frame kind |
| rx_src | input | AW | Received source address |
| rx_dst | input | AW | Received destination address |
| rx_flag | input | 1 | Received eligible/accept flag |
| tx_valid | output | 1 | Send request |
| tx_kind | output | 3 | Frame kind to send |
| tx_dst | output | AW | Destination of frame to send |
| tx_flag | output | 1 | Flag of frame to send |
| is_master | output | 1 | Node currently holds mastership |
| collision | output | 1 | One-cycle pulse on detected master collision |

## Verification
Every reply or role change is registered, so it is visible one cycle after the strobe that caused it. Time-outs count edges from the edge that entered the state: a query appears `turn_len` cycles after a turn begins, and a missing reply ends the wait `reply_len` cycles after the query or offer. A silent standby takes over `standby_len` idle cycles after its last received frame. The bench drives each frame for one cycle at a falling edge, samples at the next falling edge, and counts falling edges to compare every delay with its exact value. A two-node ring on a one-cycle-delay broadcast model also checks that mastership rotates, that no cycle is left without a master, and that any overlap of two masters lasts at most two cycles.

// File: rtl/bus_token_ctrl.sv
module bus_token_ctrl #(
  parameter int AW   = 4,
  parameter int RING = 3,
  parameter int CW   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_master,
  input  logic              admin_ok,
  input  logic [AW-1:0]     my_addr,
  input  logic [RING*AW-1:0] ring_list,
  input  logic [CW-1:0]     turn_len,
  input  logic [CW-1:0]     reply_len,
  input  logic [CW-1:0]     standby_len,
  input  logic              rx_valid,
  input  logic [2:0]        rx_kind,
  input  logic [AW-1:0]     rx_src,
  input  logic [AW-1:0]     rx_dst,
  input  logic              rx_flag,
  output logic              tx_valid,
  output logic [2:0]        tx_kind,
  output logic [AW-1:0]     tx_dst,
  output logic              tx_flag,
  output logic              is_master,
  output logic              collision
);
  localparam int IW = (RING > 1) ? $clog2(RING) : 1;
  localparam logic [2:0] K_OFFER = 3'd0, K_ORSP = 3'd1, K_QRY = 3'd2, K_QRSP = 3'd3, K_MFRM = 3'd4;

  typedef enum logic [1:0] {ST_STBY, ST_TURN, ST_PROBE, ST_OFFER} st_t;
  st_t st;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;

  wire [AW-1:0] peer    = ring_list[idx*AW +: AW];
  wire          to_me   = rx_valid && rx_dst == my_addr;
  wire          from_pr = to_me && rx_src == peer;
  wire          rival   = rx_valid && rx_src != my_addr &&
                          (rx_kind == K_MFRM || rx_kind == K_QRY || rx_kind == K_OFFER);
  wire [IW-1:0] idx_nx  = (idx == IW'(RING - 1)) ? '0 : idx + 1'b1;
  wire          turn_end  = cnt == turn_len - 1'b1;
  wire          reply_end = cnt == reply_len - 1'b1;
  wire          quiet_end = cnt == standby_len - 1'b1;

  assign is_master = st != ST_STBY;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= init_master ? ST_TURN : ST_STBY;
      cnt <= '0;
      idx <= '0;
      tx_valid <= 1'b0;
      tx_kind <= '0;
      tx_dst <= '0;
      tx_flag <= 1'b0;
      collision <= 1'b0;
    end else begin
      tx_valid <= 1'b0;
      tx_flag <= 1'b0;
      collision <= 1'b0;
      cnt <= cnt + 1'b1;
      if (is_master && rival) begin
        st <= ST_STBY;
        cnt <= '0;
        collision <= 1'b1;
      end else begin
        case (st)
          ST_STBY: begin
            if (to_me && rx_kind == K_QRY) begin
              cnt <= '0;
              tx_valid <= 1'b1; tx_kind <= K_QRSP; tx_dst <= rx_src; tx_flag <= admin_ok;
            end else if (to_me && rx_kind == K_OFFER) begin
              cnt <= '0;
              tx_valid <= 1'b1; tx_kind <= K_ORSP; tx_dst <= rx_src; tx_flag <= admin_ok;
              if (admin_ok) st <= ST_TURN;
            end else if (rx_valid) begin
              cnt <= '0;
            end else if (quiet_end) begin
              st <= ST_TURN;
              cnt <= '0;
              tx_valid <= 1'b1; tx_kind <= K_MFRM; tx_dst <= '1;
            end
          end
          ST_TURN: begin
            if (turn_end) begin
              st <= ST_PROBE;
              cnt <= '0;
              tx_valid <= 1'b1; tx_kind <= K_QRY; tx_dst <= peer;
            end
          end
          ST_PROBE: begin
            if (from_pr && rx_kind == K_QRSP) begin
              cnt <= '0;
              if (rx_flag) begin
                st <= ST_OFFER;
                tx_valid <= 1'b1; tx_kind <= K_OFFER; tx_dst <= peer;
              end else begin
                st <= ST_TURN;
                idx <= idx_nx;
                tx_valid <= 1'b1; tx_kind <= K_MFRM; tx_dst <= '1;
              end
            end else if (reply_end) begin
              st <= ST_TURN;
              cnt <= '0;
              idx <= idx_nx;
              tx_valid <= 1'b1; tx_kind <= K_MFRM; tx_dst <= '1;
            end
          end
          default: begin
            if (from_pr && rx_kind == K_ORSP) begin
              cnt <= '0;
              if (rx_flag) begin
                st <= ST_STBY;
              end else begin
                st <= ST_TURN;
                idx <= idx_nx;
                tx_valid <= 1'b1; tx_kind <= K_MFRM; tx_dst <= '1;
              end
            end else if (reply_end) begin
              st <= ST_STBY;
              cnt <= '0;
            end
          end
        endcase
      end
    end
  end

  AST_TURN_QUERY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TURN && turn_end && !rival) |=> (tx_valid && tx_kind == K_QRY)); // R2

  AST_ELIGIBLE_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PROBE && from_pr && rx_kind == K_QRSP && rx_flag) |=> (tx_valid && tx_kind == K_OFFER && is_master)); // R3

  AST_ACCEPT_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OFFER && from_pr && rx_kind == K_ORSP && rx_flag) |=> !is_master); // R5

  AST_REJECT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OFFER && from_pr && rx_kind == K_ORSP && !rx_flag) |=> (is_master && tx_valid && tx_kind == K_MFRM)); // R6

  AST_QUERY_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STBY && to_me && rx_kind == K_QRY) |=>
      (tx_valid && tx_kind == K_QRSP && tx_dst == $past(rx_src) && tx_flag == $past(admin_ok))); // R7

  AST_SILENCE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STBY && !rx_valid && quiet_end) |=> is_master); // R8

  AST_COLLISION_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && rival) |=> (!is_master && collision)); // R9
endmodule

// File: tb/bus_token_ctrl_bench.sv
module bus_token_ctrl_bench;
  localparam int AW = 4, RING = 3, CW = 8;
  localparam logic [2:0] K_OFFER = 3'd0, K_ORSP = 3'd1, K_QRY = 3'd2, K_QRSP = 3'd3, K_MFRM = 3'd4;
  localparam int TURN = 5, REPLY = 4, QUIET = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic admin_ok = 1'b1;
  logic rx_valid = 1'b0, rx_flag = 1'b0;
  logic [2:0] rx_kind = '0;
  logic [AW-1:0] rx_src = '0, rx_dst = '0;
  logic tx_valid, tx_flag, is_master, collision;
  logic [2:0] tx_kind;
  logic [AW-1:0] tx_dst;
  int total = 0, bad = 0, n = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bus_token_ctrl #(.AW(AW), .RING(RING), .CW(CW)) u_bus_token_ctrl (
    .clk(clk), .rst_n(rst_n), .init_master(1'b1), .admin_ok(admin_ok), .my_addr(4'd1),
    .ring_list({4'd5, 4'd3, 4'd2}), .turn_len(8'(TURN)), .reply_len(8'(REPLY)), .standby_len(8'(QUIET)),
    .rx_valid(rx_valid), .rx_kind(rx_kind), .rx_src(rx_src), .rx_dst(rx_dst), .rx_flag(rx_flag),
    .tx_valid(tx_valid), .tx_kind(tx_kind), .tx_dst(tx_dst), .tx_flag(tx_flag),
    .is_master(is_master), .collision(collision));

  // two-node ring on a broadcast model with one register stage each way
  logic a_tv, a_tf, a_m, a_c, b_tv, b_tf, b_m, b_c;
  logic [2:0] a_tk, b_tk;
  logic [AW-1:0] a_td, b_td;
  logic ra_v = 1'b0, ra_f = 1'b0, rb_v = 1'b0, rb_f = 1'b0;
  logic [2:0] ra_k = '0, rb_k = '0;
  logic [AW-1:0] ra_d = '0, rb_d = '0;

  always @(posedge clk) begin
    ra_v <= b_tv; ra_k <= b_tk; ra_d <= b_td; ra_f <= b_tf;
    rb_v <= a_tv; rb_k <= a_tk; rb_d <= a_td; rb_f <= a_tf;
  end

  bus_token_ctrl #(.AW(AW), .RING(RING), .CW(CW)) u_ring_a (
    .clk(clk), .rst_n(rst_n), .init_master(1'b1), .admin_ok(1'b1), .my_addr(4'd1),
    .ring_list({4'd2, 4'd2, 4'd2}), .turn_len(8'd5), .reply_len(8'd6), .standby_len(8'd12),
    .rx_valid(ra_v), .rx_kind(ra_k), .rx_src(4'd2), .rx_dst(ra_d), .rx_flag(ra_f),
    .tx_valid(a_tv), .tx_kind(a_tk), .tx_dst(a_td), .tx_flag(a_tf), .is_master(a_m), .collision(a_c));

  bus_token_ctrl #(.AW(AW), .RING(RING), .CW(CW)) u_ring_b (
    .clk(clk), .rst_n(rst_n), .init_master(1'b0), .admin_ok(1'b1), .my_addr(4'd2),
    .ring_list({4'd1, 4'd1, 4'd1}), .turn_len(8'd5), .reply_len(8'd6), .standby_len(8'd12),
    .rx_valid(rb_v), .rx_kind(rb_k), .rx_src(4'd1), .rx_dst(rb_d), .rx_flag(rb_f),
    .tx_valid(b_tv), .tx_kind(b_tk), .tx_dst(b_td), .tx_flag(b_tf), .is_master(b_m), .collision(b_c));

  int run_both = 0, max_both = 0, run_none = 0, max_none = 0, b_rises = 0, coll_seen = 0;
  logic b_prev = 1'b0;
  always @(negedge clk) if (rst_n) begin
    run_both = (a_m && b_m) ? run_both + 1 : 0;
    run_none = (!a_m && !b_m) ? run_none + 1 : 0;
    if (run_both > max_both) max_both = run_both;
    if (run_none > max_none) max_none = run_none;
    if (b_m && !b_prev) b_rises++;
    if (a_c || b_c) coll_seen++;
    b_prev = b_m;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [2:0] k, input int src, input int dst, input logic f);
    rx_valid = 1'b1; rx_kind = k; rx_src = AW'(src); rx_dst = AW'(dst); rx_flag = f;
    @(negedge clk);
    rx_valid = 1'b0; rx_flag = 1'b0;
  endtask

  task automatic wait_tx(output int cnt);
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!tx_valid && cnt < 40);
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 master during reset", int'(is_master), 1);
    rst_n = 1'b1;
    chk("R1 tx idle at reset", int'(tx_valid), 0);
    chk("R1 collision low at reset", int'(collision), 0);
    chk("R1 standby node at reset", int'(b_m), 0);

    wait_tx(n);
    chk("R2 turn length", n, TURN);
    chk("R2 query kind", int'(tx_kind), K_QRY);
    chk("R2 query to entry0", int'(tx_dst), 2);

    put(K_QRSP, 2, 1, 1'b0);
    chk("R4 ineligible -> new turn frame", int'(tx_valid && tx_kind == K_MFRM), 1);
    chk("R4 still master", int'(is_master), 1);
    wait_tx(n);
    chk("R4 turn length again", n, TURN);
    chk("R4 query to entry1", int'(tx_dst), 3);

    wait_tx(n);
    chk("R4 no status reply window", n, REPLY);
    chk("R4 new turn frame kind", int'(tx_kind), K_MFRM);
    wait_tx(n);
    chk("R4 query to entry2", int'(tx_dst), 5);

    put(K_QRSP, 5, 1, 1'b1);
    chk("R3 offer kind", int'(tx_valid && tx_kind == K_OFFER), 1);
    chk("R3 offer dst", int'(tx_dst), 5);
    put(K_ORSP, 5, 1, 1'b0);
    chk("R6 reject keeps master", int'(is_master), 1);
    chk("R6 reject starts turn", int'(tx_valid && tx_kind == K_MFRM), 1);
    wait_tx(n);
    chk("R6 turn length", n, TURN);
    chk("R6 wrap to entry0", int'(tx_dst), 2);

    put(K_QRSP, 2, 1, 1'b1);
    chk("R3 offer to entry0", int'(tx_valid && tx_kind == K_OFFER && tx_dst == 2), 1);
    put(K_ORSP, 2, 1, 1'b1);
    chk("R5 accept retires", int'(is_master), 0);

    repeat (6) @(negedge clk);
    chk("R8 still standby before time-out", int'(is_master), 0);
    put(K_MFRM, 7, 15, 1'b0);
    n = 1;
    while (!is_master && n < 40) begin @(negedge clk); n++; end
    chk("R8 silence restart then take-over", n, QUIET + 1);
    chk("R8 take-over master frame", int'(tx_valid && tx_kind == K_MFRM), 1);

    put(K_MFRM, 1, 15, 1'b0);
    chk("R9 own frame ignored", int'(is_master), 1);
    chk("R9 no pulse on own frame", int'(collision), 0);
    put(K_MFRM, 6, 15, 1'b0);
    chk("R9 rival drops master", int'(is_master), 0);
    chk("R9 collision pulse", int'(collision), 1);
    @(negedge clk);
    chk("R9 pulse one cycle", int'(collision), 0);

    put(K_QRY, 6, 3, 1'b0);
    chk("R10 query to other ignored", int'(tx_valid), 0);
    put(K_QRY, 6, 1, 1'b0);
    chk("R7 status reply", int'(tx_valid && tx_kind == K_QRSP && tx_dst == 6), 1);
    chk("R7 status flag", int'(tx_flag), 1);
    admin_ok = 1'b0;
    put(K_OFFER, 6, 1, 1'b0);
    chk("R7 decline reply", int'(tx_valid && tx_kind == K_ORSP && tx_flag == 0), 1);
    chk("R7 decline stays standby", int'(is_master), 0);
    admin_ok = 1'b1;
    put(K_OFFER, 6, 1, 1'b0);
    chk("R7 accept reply", int'(tx_valid && tx_kind == K_ORSP && tx_flag == 1), 1);
    chk("R7 accept takes mastership", int'(is_master), 1);

    wait_tx(n);
    chk("R2 turn after accepted offer", n, TURN);
    chk("R2 query entry0", int'(tx_dst), 2);
    put(K_QRSP, 3, 1, 1'b1);
    chk("R10 reply from wrong node ignored", int'(tx_valid), 0);
    wait_tx(n);
    chk("R4 window still runs", n, REPLY - 1);
    wait_tx(n);
    chk("R4 next entry after timeout", int'(tx_dst), 3);
    put(K_QRSP, 3, 1, 1'b1);
    chk("R3 offer entry1", int'(tx_valid && tx_kind == K_OFFER && tx_dst == 3), 1);
    n = 0;
    while (is_master && n < 40) begin @(negedge clk); n++; end
    chk("R5 no answer retires", n, REPLY);

    repeat (300) @(negedge clk);
    chk("R5 ring rotates to node b", int'(b_rises >= 3), 1);
    chk("R7 ring overlap bounded", int'(max_both <= 2), 1);
    chk("R7 ring never masterless", max_none, 0);
    chk("R9 ring no collision", coll_seen, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule